// File: doc/BRIEF.md
# UART FIFO Ready and Interrupt Signalling

This block generates the host-side handshake for one UART channel whose transmit and receive FIFOs are each 16 characters deep. It receives the occupancy of both FIFOs, a strobe each time a character leaves the transmit FIFO for the shifter or enters the receive FIFO, and three control inputs: FIFO enable, transfer-mode select and a 2-bit receive threshold code. From these it drives two active-low ready pins, an interrupt request and two transmitter status bits.

Two transfer styles are supported. In character mode the interrupt request fires for every character moved in either direction, and the ready pins report single-character availability. In block mode the interrupt is held quiet and the ready pins follow FIFO thresholds, so a DMA engine can move a burst per request. When the FIFOs are disabled the block runs in character mode and treats each FIFO as one character deep. The FIFOs, the serializer and the bus decode are outside this block.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `tx_rdy_n`=1, `rx_rdy_n`=1, `irq`=0, `thr_room`=1 and `tx_idle`=1.
- R2: Block mode is in force only when `fifo_en`=1 and `dma_sel`=1. With `fifo_en`=0, `dma_sel` has no effect and the block runs in character mode.
- R3: In block mode, `tx_rdy_n` is 0 exactly when `tx_count` is below 16.
- R4: In block mode, `rx_rdy_n` is 0 exactly when `rx_count` is strictly greater than the threshold. The threshold for `rx_trig` codes 0, 1, 2 and 3 is 1, 4, 8 and 14 characters.
- R5: In character mode, `tx_rdy_n` is 0 exactly when `tx_count` is 0.
- R6: In character mode, `rx_rdy_n` is 0 exactly when `rx_count` is at least 1.
- R7: In character mode, `irq` is 1 for the single cycle after each cycle in which `tx_pop` or `rx_push` is 1, and 0 otherwise. In block mode, `irq` stays 0 whatever the strobes do.
- R8: `thr_room` is 1 exactly when `tx_count` is below the effective depth. The effective depth is 16 with `fifo_en`=1 and 1 with `fifo_en`=0.
- R9: `tx_idle` is 1 exactly when `tx_count` is 0 and `tx_shift_empty` is 1.
- R10: Every output is registered. It reflects the inputs sampled at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFOs enabled |
| dma_sel | input | 1 | Selects block mode while FIFOs are enabled |
| rx_trig | input | 2 | Receive threshold code |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_shift_empty | input | 1 | Transmit shift register holds no character |
| tx_pop | input | 1 | A character left the transmit FIFO this cycle |
| rx_push | input | 1 | A character entered the receive FIFO this cycle |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| rx_rdy_n | output | 1 | Receive ready, active low |
| irq | output | 1 | Per-character interrupt request |
| thr_room | output | 1 | Transmit side has a free location |
| tx_idle | output | 1 | Transmit FIFO and shifter both empty |

## Verification
The assertions check on every cycle several properties. In block mode the interrupt stays quiet. A free transmit location in block mode, or a receive count above the threshold, drives the matching ready pin active on the next edge. An empty receive FIFO always leaves its ready pin inactive. An idle transmitter always reports room. Some behaviour only the bench scenarios can show. These cover the exact threshold boundaries for each trigger code, and the switch to a depth of one with the FIFOs disabled. They also cover the one-cycle interrupt pulses for back-to-back strobes, and the fact that `dma_sel` has no effect while the FIFOs are off.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    typedef enum logic {
        MODE_CHAR  = 1'b0,
        MODE_BLOCK = 1'b1
    } xfer_mode_t;

    typedef struct packed {
        logic tx_rdy_n;
        logic rx_rdy_n;
        logic irq;
        logic thr_room;
        logic tx_idle;
    } ready_flags_t;

    // Threshold in characters for a 2-bit code, scaled from the FIFO depth.
    function automatic int unsigned trig_bytes(input logic [1:0] code,
                                               input int unsigned depth);
        case (code)
            2'd0:    trig_bytes = 1;
            2'd1:    trig_bytes = depth / 4;
            2'd2:    trig_bytes = depth / 2;
            default: trig_bytes = depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import uart_dma_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic             dma_sel,
    input  logic [1:0]       trig_code,
    output xfer_mode_t       mode,
    output logic [CNT_W-1:0] eff_depth,
    output logic [CNT_W-1:0] trig_cnt
);

    always_comb begin
        mode      = (fifo_en && dma_sel) ? MODE_BLOCK : MODE_CHAR;
        eff_depth = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        trig_cnt  = CNT_W'(trig_bytes(trig_code, DEPTH));
    end

endmodule

// File: rtl/dma_tx_ready.sv
module dma_tx_ready
    import uart_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_t       mode,
    input  logic [CNT_W-1:0] eff_depth,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_shift_empty,
    output logic             tx_rdy_n,
    output logic             thr_room,
    output logic             tx_idle
);

    logic has_room;
    logic fifo_empty;

    always_comb begin
        has_room   = tx_count < eff_depth;
        fifo_empty = (tx_count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_rdy_n <= 1'b1;
            thr_room <= 1'b1;
            tx_idle  <= 1'b1;
        end else begin
            tx_rdy_n <= (mode == MODE_BLOCK) ? !has_room : !fifo_empty;
            thr_room <= has_room;
            tx_idle  <= fifo_empty && tx_shift_empty;
        end
    end

    assert_block_tx_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && tx_count < eff_depth) |=> !tx_rdy_n);

    assert_char_tx_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAR && tx_count != '0) |=> tx_rdy_n);

    assert_idle_has_room_R9: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> thr_room);

endmodule

// File: rtl/dma_rx_ready.sv
module dma_rx_ready
    import uart_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_t       mode,
    input  logic [CNT_W-1:0] trig_cnt,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rx_rdy_n
);

    logic above_trig;
    logic not_empty;

    always_comb begin
        above_trig = rx_count > trig_cnt;
        not_empty  = (rx_count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_rdy_n <= 1'b1;
        end else begin
            rx_rdy_n <= (mode == MODE_BLOCK) ? !above_trig : !not_empty;
        end
    end

    assert_block_rx_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && rx_count > trig_cnt) |=> !rx_rdy_n);

    assert_empty_rx_inactive_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> rx_rdy_n);

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
    import uart_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  xfer_mode_t mode,
    input  logic       tx_pop,
    input  logic       rx_push,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= (mode == MODE_CHAR) && (tx_pop || rx_push);
        end
    end

    assert_block_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK) |=> !irq);

    assert_no_idle_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (!tx_pop && !rx_push) |=> !irq);

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dma_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             dma_sel,
    input  logic [1:0]       rx_trig,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tx_shift_empty,
    input  logic             tx_pop,
    input  logic             rx_push,
    output logic             tx_rdy_n,
    output logic             rx_rdy_n,
    output logic             irq,
    output logic             thr_room,
    output logic             tx_idle
);

    xfer_mode_t       mode;
    logic [CNT_W-1:0] eff_depth;
    logic [CNT_W-1:0] trig_cnt;
    ready_flags_t     flags;

    dma_mode_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_decode (
        .fifo_en   (fifo_en),
        .dma_sel   (dma_sel),
        .trig_code (rx_trig),
        .mode      (mode),
        .eff_depth (eff_depth),
        .trig_cnt  (trig_cnt)
    );

    dma_tx_ready #(.CNT_W(CNT_W)) u_tx (
        .clk            (clk),
        .rst            (rst),
        .mode           (mode),
        .eff_depth      (eff_depth),
        .tx_count       (tx_count),
        .tx_shift_empty (tx_shift_empty),
        .tx_rdy_n       (flags.tx_rdy_n),
        .thr_room       (flags.thr_room),
        .tx_idle        (flags.tx_idle)
    );

    dma_rx_ready #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .trig_cnt (trig_cnt),
        .rx_count (rx_count),
        .rx_rdy_n (flags.rx_rdy_n)
    );

    dma_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .tx_pop  (tx_pop),
        .rx_push (rx_push),
        .irq     (flags.irq)
    );

    always_comb begin
        tx_rdy_n = flags.tx_rdy_n;
        rx_rdy_n = flags.rx_rdy_n;
        irq      = flags.irq;
        thr_room = flags.thr_room;
        tx_idle  = flags.tx_idle;
    end

    // Disabled FIFOs must force character mode whatever dma_sel says.
    assert_off_forces_char_R2: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (mode == MODE_CHAR));

    // The counts must stay within the effective depth.
    assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= eff_depth) && (rx_count <= eff_depth));

endmodule

// File: tb/tb_uart_dma_ready.sv
module tb_uart_dma_ready;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic       dma_sel = 1'b0;
    logic [1:0] rx_trig = 2'd0;
    logic [4:0] tx_count = 5'd0;
    logic [4:0] rx_count = 5'd0;
    logic       tx_shift_empty = 1'b1;
    logic       tx_pop = 1'b0;
    logic       rx_push = 1'b0;
    logic       tx_rdy_n, rx_rdy_n, irq, thr_room, tx_idle;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // Reference model state, updated at each rising edge.
    bit    e_tx_rdy_n, e_rx_rdy_n, e_irq, e_room, e_idle;
    bit    e_block, e_was_rst, e_off_sel;

    always #4 clk = ~clk;

    uart_dma_ready dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_sel(dma_sel),
        .rx_trig(rx_trig), .tx_count(tx_count), .rx_count(rx_count),
        .tx_shift_empty(tx_shift_empty), .tx_pop(tx_pop), .rx_push(rx_push),
        .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .irq(irq),
        .thr_room(thr_room), .tx_idle(tx_idle)
    );

    function automatic int thresh(input int code);
        int lv[4] = '{1, 4, 8, 14};
        return lv[code];
    endfunction

    // R10: expected outputs follow the inputs seen at the last rising edge.
    always @(posedge clk) begin
        int depth;
        int txc;
        int rxc;
        txc   = int'(tx_count);
        rxc   = int'(rx_count);
        depth = fifo_en ? 16 : 1;
        e_was_rst = rst;
        e_off_sel = !fifo_en && dma_sel;
        if (rst) begin
            e_tx_rdy_n = 1; e_rx_rdy_n = 1; e_irq = 0; e_room = 1; e_idle = 1;
            e_block = 0;
        end else begin
            e_block    = fifo_en && dma_sel;
            e_tx_rdy_n = e_block ? !(txc < 16) : (txc != 0);
            e_rx_rdy_n = e_block ? !(rxc > thresh(int'(rx_trig))) : (rxc == 0);
            e_irq      = !e_block && (tx_pop || rx_push);
            e_room     = txc < depth;
            e_idle     = (txc == 0) && tx_shift_empty;
        end
    end

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            if (e_was_rst) begin
                check("R1", "tx_rdy_n", tx_rdy_n, e_tx_rdy_n);
                check("R1", "rx_rdy_n", rx_rdy_n, e_rx_rdy_n);
                check("R1", "irq", irq, e_irq);
                check("R1", "thr_room", thr_room, e_room);
                check("R1", "tx_idle", tx_idle, e_idle);
            end else begin
                check(e_off_sel ? "R2" : (e_block ? "R3" : "R5"), "tx_rdy_n", tx_rdy_n, e_tx_rdy_n);
                check(e_off_sel ? "R2" : (e_block ? "R4" : "R6"), "rx_rdy_n", rx_rdy_n, e_rx_rdy_n);
                check(e_off_sel ? "R2" : "R7", "irq", irq, e_irq);
                check("R8", "thr_room", thr_room, e_room);
                check("R9", "tx_idle", tx_idle, e_idle);
            end
        end
    end

    task automatic cyc(input int tx, input int rx, input bit shf, input bit pop, input bit push);
        @(negedge clk);
        tx_count = 5'(tx); rx_count = 5'(rx);
        tx_shift_empty = shf; tx_pop = pop; rx_push = push;
    endtask

    task automatic sweep(input int limit);
        for (int t = 0; t < 4; t++) begin
            rx_trig = 2'(t);
            for (int n = 0; n <= limit; n++) cyc(n, n, n[0], 1'b0, 1'b0);
        end
    endtask

    initial begin
        @(posedge clk); #1 armed = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R3 R4: block mode sweep over all counts and thresholds
        fifo_en = 1; dma_sel = 1;
        sweep(16);
        // R7: strobes in block mode give no interrupt
        cyc(3, 3, 0, 1, 1); cyc(3, 3, 0, 1, 0); cyc(3, 3, 0, 0, 1);
        // R5 R6: character mode sweep
        dma_sel = 0;
        sweep(16);
        // R7: single, back-to-back and idle strobes
        cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 0, 0); cyc(1, 1, 0, 1, 1);
        cyc(1, 1, 0, 0, 1); cyc(1, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0);
        // R2 R8: FIFOs disabled, dma_sel has no effect, depth of one
        fifo_en = 0; dma_sel = 1;
        sweep(1);
        cyc(1, 1, 0, 1, 1); cyc(0, 0, 1, 0, 0);
        dma_sel = 0;
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 1, 0, 1);
        // R9: shifter busy with an empty FIFO
        fifo_en = 1;
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0);
        // R1: reset mid-run
        rst = 1; cyc(16, 16, 0, 1, 1); cyc(16, 16, 0, 1, 1);
        rst = 0; cyc(0, 0, 1, 0, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule